// File: doc/BRIEF.md
# Dual-Protocol Two-Wire Register Slave

This block is a slave on a two-wire serial bus that exposes a bank of byte-wide configuration registers. The bus clock and data lines arrive as plain logic levels. They are brought into the system clock domain, and the block watches them for start and stop conditions and for clock edges. The seven-bit device address the master sends after a start selects how the bytes that follow are decoded. One address gives a plain register protocol: a pointer byte, then data, with the pointer advancing after each byte. The other address gives a block protocol: a command byte that sets the first register, then a byte count, then data. On reads in this mode, the count comes back ahead of the data.

The block drives the bus only through an open-drain enable, which pulls data low when it is high. Every register is also presented in parallel on a flat output bus so that surrounding logic can use the configuration directly. Writes that run past the last register continue at register 0 and overwrite the older contents in turn.

Top module: `dmr_reg_slave`

## Requirements
- R1: While reset is held and after it is released, `sda_oe` is 0 and every register reads 0.
- R2: The block acknowledges device address 7'b1101010 (register mode) and 7'b1101001 (block mode), with the R/W bit as bit 0 of the address byte (0 = write). It acknowledges each byte it receives after that by pulling data low during the ninth clock high.
- R3: Any other device address is not acknowledged. Bytes that follow it, up to the next START, are neither acknowledged nor written.
- R4: In register mode, the first written byte sets the register pointer to its low 3 bits, and the next byte is stored in that register. Register n appears on `regs_out[8n+7:8n]`.
- R5: Sequential writes advance the pointer after each data byte. The pointer wraps from register 7 to register 0 and overwrites it, then register 1, and so on.
- R6: A read returns the register at the pointer, MSB first, then advances the pointer with the same wrap. This holds both for a random read (pointer write, repeated START, read address) and for a sequential read.
- R7: When the master does not acknowledge a read byte, the block releases data and keeps it released until the next START.
- R8: In block mode a write carries a command byte that sets the starting register, then a count byte that is stored nowhere, then data bytes that are written from that register onward.
- R9: A block-mode read returns the value 8 (the register count) first, then the registers from the command pointer onward.
- R10: A START in the middle of a byte discards the partial byte and restarts address reception from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled bus clock level |
| sda_in | input | 1 | Sampled bus data level |
| sda_oe | output | 1 | Pull data low when 1 (open drain) |
| regs_out | output | 64 | All registers, register n at bits 8n+7:8n |

## Verification
The bus clock fall that ends a data byte does two things in the same system cycle. It commits the register write and the pointer increment, and it raises the acknowledge drive. A long sequential write that crosses the top of the bank makes the wrap increment land on exactly that shared cycle. The result is judged by checking that every byte is acknowledged and that the register image matches a model that overwrote registers 6, 7 and then 0 upward. A second overlap is a START arriving while a byte is half shifted. That case is provoked by cutting an address after three bits, and it is judged by a clean acknowledge and write for the transaction that follows.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    typedef enum logic [1:0] {
        MODE_NONE,
        MODE_REG,
        MODE_BLK
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_TX,
        ST_WAIT
    } state_e;

    // Bus events in the system clock domain
    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic mode_e decode_addr(input logic [6:0] a,
                                          input logic [6:0] reg_addr,
                                          input logic [6:0] blk_addr);
        if (a == reg_addr)      return MODE_REG;
        else if (a == blk_addr) return MODE_BLK;
        else                    return MODE_NONE;
    endfunction

endpackage

// File: rtl/dmr_sync.sv
module dmr_sync #(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    output dmr_pkg::bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        ev.scl   = scl_pipe[STAGES-1];
        ev.sda   = sda_pipe[STAGES-1];
        ev.start = ev.scl && scl_d && sda_d && !ev.sda;
        ev.stop  = ev.scl && scl_d && !sda_d && ev.sda;
        ev.rise  = ev.scl && !scl_d;
        ev.fall  = !ev.scl && scl_d;
    end
endmodule

// File: rtl/dmr_regbank.sv
module dmr_regbank #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    localparam int PW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [PW-1:0]      wr_ptr,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)                                r <= '0;
            else if (wr_en && wr_ptr == PW'(g))     r <= wr_data;
        end
        assign regs_flat[g*DW +: DW] = r;
    end
endmodule

// File: rtl/dmr_proto.sv
module dmr_proto
    import dmr_pkg::*;
#(
    parameter int         NREG     = 8,
    parameter int         DW       = 8,
    parameter logic [6:0] REG_ADDR = 7'b1101010,
    parameter logic [6:0] BLK_ADDR = 7'b1101001,
    localparam int        PW       = $clog2(NREG),
    localparam int        BCW      = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [DW-1:0] rd_data,
    output logic [PW-1:0] ptr,
    output logic          wr_en,
    output logic [PW-1:0] wr_ptr,
    output logic [DW-1:0] wr_data,
    output logic          sda_oe,
    output mode_e         mode
);
    state_e         st;
    logic [BCW-1:0] bitcnt;
    logic           ackph, rw, nack, cnt_pend;
    logic [1:0]     rxidx;
    logic [DW-1:0]  sh, txsh, tx_next;
    mode_e          hit;

    assign hit     = decode_addr(sh[DW-1 -: 7], REG_ADDR, BLK_ADDR);
    assign tx_next = cnt_pend ? DW'(NREG) : rd_data;

    function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
        return (p == PW'(NREG - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            mode     <= MODE_NONE;
            bitcnt   <= '0;
            ackph    <= 1'b0;
            rw       <= 1'b0;
            nack     <= 1'b0;
            cnt_pend <= 1'b0;
            rxidx    <= '0;
            sh       <= '0;
            txsh     <= '0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_ptr   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                st     <= ST_ADDR;
                bitcnt <= '0;
                ackph  <= 1'b0;
                nack   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                mode   <= MODE_NONE;
                ackph  <= 1'b0;
                sda_oe <= 1'b0;
            end else if (st == ST_ADDR || st == ST_RX || st == ST_TX) begin
                if (ev.rise) begin
                    if (ackph) begin
                        if (st == ST_TX) nack <= ev.sda;
                    end else begin
                        sh     <= {sh[DW-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end else if (ev.fall) begin
                    if (ackph) begin
                        // end of the ninth clock
                        ackph  <= 1'b0;
                        bitcnt <= '0;
                        if ((st == ST_ADDR && rw) || (st == ST_TX && !nack)) begin
                            st     <= ST_TX;
                            txsh   <= tx_next;
                            sda_oe <= ~tx_next[DW-1];
                            if (cnt_pend) cnt_pend <= 1'b0;
                            else          ptr      <= inc(ptr);
                        end else if (st == ST_TX) begin
                            st     <= ST_WAIT;
                            sda_oe <= 1'b0;
                        end else begin
                            st     <= ST_RX;
                            sda_oe <= 1'b0;
                        end
                    end else if (bitcnt == BCW'(DW)) begin
                        ackph <= 1'b1;
                        unique case (st)
                            ST_ADDR: begin
                                if (hit == MODE_NONE) begin
                                    st    <= ST_WAIT;
                                    mode  <= MODE_NONE;
                                    ackph <= 1'b0;
                                end else begin
                                    mode     <= hit;
                                    rw       <= sh[0];
                                    sda_oe   <= 1'b1;
                                    rxidx    <= '0;
                                    cnt_pend <= (hit == MODE_BLK) && sh[0];
                                end
                            end
                            ST_RX: begin
                                sda_oe <= 1'b1;
                                if (rxidx < 2'd2) rxidx <= rxidx + 1'b1;
                                if (rxidx == 2'd0) begin
                                    ptr <= sh[PW-1:0];
                                end else if (!(mode == MODE_BLK && rxidx == 2'd1)) begin
                                    wr_en   <= 1'b1;
                                    wr_ptr  <= ptr;
                                    wr_data <= sh;
                                    ptr     <= inc(ptr);
                                end
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (st == ST_TX) begin
                        txsh   <= {txsh[DW-2:0], 1'b0};
                        sda_oe <= ~txsh[DW-2];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dmr_reg_slave.sv
module dmr_reg_slave
    import dmr_pkg::*;
#(
    parameter int         NREG     = 8,
    parameter int         DW       = 8,
    parameter int         STAGES   = 2,
    parameter logic [6:0] REG_ADDR = 7'b1101010,
    parameter logic [6:0] BLK_ADDR = 7'b1101001,
    localparam int        PW       = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic [NREG*DW-1:0] regs_out
);
    bus_ev_t       ev;
    logic [PW-1:0] ptr, wr_ptr;
    logic          wr_en;
    logic [DW-1:0] wr_data, rd_data;
    mode_e         mode;

    dmr_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    assign rd_data = regs_out[ptr*DW +: DW];

    dmr_proto #(
        .NREG(NREG), .DW(DW), .REG_ADDR(REG_ADDR), .BLK_ADDR(BLK_ADDR)
    ) u_proto (
        .clk(clk), .rst(rst), .ev(ev), .rd_data(rd_data), .ptr(ptr),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
        .sda_oe(sda_oe), .mode(mode)
    );

    dmr_regbank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_data(wr_data), .regs_flat(regs_out)
    );
endmodule

// File: rtl/dmr_reg_slave_chk.sv
module dmr_reg_slave_chk
    import dmr_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input bus_ev_t ev,
    input logic    sda_oe,
    input logic    wr_en,
    input mode_e   mode
);
    // R1: reset leaves the bus released
    a_r1_reset_release: assert property (@(posedge clk) rst |=> !sda_oe);

    // R2: drive only changes while the bus clock is low (start/stop excepted)
    a_r2_oe_steady_high: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl) && !$past(ev.start) && !$past(ev.stop))
        |-> $stable(sda_oe));

    // R3: no write unless an address matched
    a_r3_write_needs_match: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> mode != MODE_NONE);

    // R4: writes commit during the clock low phase
    a_r4_write_in_low: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !ev.scl);

    // R7: a stop always leaves data released
    a_r7_stop_release: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);
endmodule

bind dmr_reg_slave dmr_reg_slave_chk u_chk (
    .clk(clk), .rst(rst), .ev(ev), .sda_oe(sda_oe), .wr_en(wr_en), .mode(mode)
);

// File: tb/dmr_reg_slave_bench.sv
module dmr_reg_slave_bench;
    localparam int   Q       = 8;
    localparam logic [6:0] A_REG = 7'b1101010;
    localparam logic [6:0] A_BLK = 7'b1101001;
    // {pointer byte, data}
    localparam logic [15:0] WR_VEC [5] = '{16'h03A5, 16'h003C, 16'h0781, 16'h0D5F, 16'h0106};

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    logic [63:0] regs_out;
    wire  sda_line = sda_m & ~sda_oe;
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    logic [7:0] m [8];

    always #5 clk = ~clk;

    dmr_reg_slave u_dmr_reg_slave (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .regs_out(regs_out)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] img();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = m[i];
        return v;
    endfunction

    task automatic hq(); repeat (Q) @(negedge clk); endtask

    task automatic bitc(input logic b, output logic seen);
        scl_m = 0; hq(); sda_m = b; hq(); scl_m = 1; hq(); seen = sda_line; hq(); scl_m = 0;
    endtask

    task automatic bstart();
        sda_m = 1; hq(); scl_m = 1; hq(); sda_m = 0; hq(); scl_m = 0; hq();
    endtask

    task automatic bstop();
        scl_m = 0; hq(); sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bitc(b[i], s);
        bitc(1'b1, s);
        ack = !s;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 0; i < 8; i++) begin bitc(1'b1, s); d = {d[6:0], s}; end
        bitc(!mack, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int p;
        for (int i = 0; i < 8; i++) m[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk(sda_oe == 0 && regs_out == 0, "R1 reset", {sda_oe, regs_out}, 0);
        rst = 0;
        repeat (4) @(negedge clk);
        chk(sda_oe == 0 && regs_out == 0, "R1 after release", {sda_oe, regs_out}, 0);

        // table walk: random write then random read (R4, R6, R2)
        for (int v = 0; v < 5; v++) begin
            p = WR_VEC[v][10:8];
            bstart();
            wbyte({A_REG, 1'b0}, ack); chk(ack, "R2 reg address ack", ack, 1);
            wbyte(WR_VEC[v][15:8], ack);
            wbyte(WR_VEC[v][7:0], ack); chk(ack, "R2 data ack", ack, 1);
            bstop();
            m[p] = WR_VEC[v][7:0];
            chk(regs_out == img(), "R4 random write", regs_out, img());
            bstart();
            wbyte({A_REG, 1'b0}, ack);
            wbyte(WR_VEC[v][15:8], ack);
            bstart();
            wbyte({A_REG, 1'b1}, ack);
            rbyte(1'b0, d);
            bstop();
            chk(d == m[p], "R6 random read", d, m[p]);
        end

        // R3: foreign address
        bstart();
        wbyte({7'b1010000, 1'b0}, ack); chk(!ack, "R3 no address ack", ack, 0);
        wbyte(8'h02, ack);
        wbyte(8'h77, ack); chk(!ack, "R3 no data ack", ack, 0);
        bstop();
        chk(regs_out == img(), "R3 registers untouched", regs_out, img());

        // R5: sequential write wrapping past register 7
        bstart();
        wbyte({A_REG, 1'b0}, ack);
        wbyte(8'h06, ack);
        p = 6;
        for (int i = 0; i < 10; i++) begin
            wbyte(8'h90 + 8'(i), ack);
            chk(ack, "R5 wrap byte ack", ack, 1);
            m[p] = 8'h90 + 8'(i);
            p = (p + 1) % 8;
        end
        bstop();
        chk(regs_out == img(), "R5 wrap overwrite", regs_out, img());

        // R6 sequential read with wrap, R7 release after master nack
        bstart();
        wbyte({A_REG, 1'b0}, ack);
        wbyte(8'h07, ack);
        bstart();
        wbyte({A_REG, 1'b1}, ack);
        rbyte(1'b1, d); chk(d == m[7], "R6 seq read reg7", d, m[7]);
        rbyte(1'b1, d); chk(d == m[0], "R6 seq read wrap reg0", d, m[0]);
        rbyte(1'b0, d); chk(d == m[1], "R6 seq read reg1", d, m[1]);
        rbyte(1'b1, d); chk(d == 8'hFF, "R7 released after nack", d, 8'hFF);
        bstop();

        // R8: block write, count byte not stored
        bstart();
        wbyte({A_BLK, 1'b0}, ack); chk(ack, "R2 block address ack", ack, 1);
        wbyte(8'h02, ack);
        wbyte(8'h03, ack); chk(ack, "R2 count ack", ack, 1);
        wbyte(8'h11, ack); wbyte(8'h22, ack); wbyte(8'h33, ack);
        bstop();
        m[2] = 8'h11; m[3] = 8'h22; m[4] = 8'h33;
        chk(regs_out == img(), "R8 block write", regs_out, img());

        // R9: block read returns count first
        bstart();
        wbyte({A_BLK, 1'b0}, ack);
        wbyte(8'h03, ack);
        bstart();
        wbyte({A_BLK, 1'b1}, ack);
        rbyte(1'b1, d); chk(d == 8'd8, "R9 count byte", d, 8);
        rbyte(1'b1, d); chk(d == m[3], "R9 block data reg3", d, m[3]);
        rbyte(1'b0, d); chk(d == m[4], "R9 block data reg4", d, m[4]);
        bstop();

        // R10: start cuts a partial address byte
        bstart();
        bitc(1'b1, ack); bitc(1'b0, ack); bitc(1'b1, ack);
        bstart();
        wbyte({A_REG, 1'b0}, ack); chk(ack, "R10 address after restart", ack, 1);
        wbyte(8'h00, ack);
        wbyte(8'h5A, ack);
        bstop();
        m[0] = 8'h5A;
        chk(regs_out == img(), "R10 write after restart", regs_out, img());

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule